// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block is the read side of a bit-serial configuration store that feeds a programmable logic device booting in master serial mode. It holds a one-bit-wide array (65536 bits by default) and presents one bit per configuration clock on a data output that can be released. The address counter steps on each rising clock edge while reading is allowed. The current bit is visible before the edge that moves past it. High impedance is modelled by the data-enable output being low.

Several instances can be chained. The cascade output of one feeds the chip-enable input of the next. When the last bit of an instance has been read, the next edge pulls its cascade output low and releases its data line. The downstream instance sees its enable go low and starts driving its own bit 0 in that same cycle, so the chain gives one unbroken bitstream. A shared reset/output-enable pin, whose active level is chosen by an input, rewinds every instance. A serial-enable pin selects programming mode. In that mode a simple synchronous write port preloads the array one bit at a time.

Top module: `cfg_serial_rom`

## Requirements
- R1: `data_en_o` is high only when all of these hold: `ce_n_i` is low, the reset/output-enable pin is inactive, `ser_en_n_i` is high, the cascade output is still high and the block is out of system reset. In every other case it is low and `data_o` is 0.
- R2: After reset the first bit shown is address 0. Each rising edge with `data_en_o` high moves to the next address, so the bits appear in address order 0, 1, ..., DEPTH-1.
- R3: The rising edge that moves past address DEPTH-1 drives `ceo_n_o` low and releases the data line. In a two-instance chain the combined stream is the upstream contents followed at once by the downstream contents, with no gap cycle, no repeated bit and never two drivers at once.
- R4: Once `ceo_n_o` is low, the counter neither wraps nor moves, and the data line stays released until reset/output-enable is asserted.
- R5: A rising edge with reset/output-enable active sets the counter to address 0 and `ceo_n_o` high. Held inactive, the pin never rewinds the counter.
- R6: `rst_pol_i` = 1 makes `rst_oe_i` active-high; `rst_pol_i` = 0 makes it active-low.
- R7: While `ce_n_i` is high the block is in standby. The counter holds and the data line is released. Reading resumes at the same address when `ce_n_i` returns low.
- R8: While `ser_en_n_i` is low the block is in programming mode. Read-out is suspended, the counter holds and the data line is released. A clock edge with `wr_en_i` high stores `wr_data_i` at bit address `wr_addr_i`.
- R9: `wr_en_i` has no effect on the array while `ser_en_n_i` is high.
- R10: While `rst_n` is low, `ceo_n_o` is high, the data line is released and the counter is at 0. Release of `rst_n` takes effect after two rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | System reset, asynchronous assert, active low |
| ce_n_i | input | 1 | Chip enable, active low (from upstream cascade output) |
| ceo_n_o | output | 1 | Cascade output, low once the last bit has been passed on |
| rst_oe_i | input | 1 | Reset/output-enable pin, active level set by rst_pol_i |
| rst_pol_i | input | 1 | 1: rst_oe_i active high, 0: active low |
| ser_en_n_i | input | 1 | Low selects programming mode |
| wr_en_i | input | 1 | Preload write strobe |
| wr_addr_i | input | ADDR_W | Preload bit address |
| wr_data_i | input | 1 | Preload bit value |
| data_o | output | 1 | Serial data bit (0 while released) |
| data_en_o | output | 1 | Data driver enable; low means high impedance |

## Verification
The assertions check on every cycle the conditions that gate the driver. Standby, programming mode and an asserted cascade output must each keep the data line released. The counter must hold when not advancing, freeze after the last bit and return to zero when reset/output-enable is asserted. Only the bench scenarios can show that the bits come out in the preloaded order and that two chained instances join into one stream without a gap or a doubled bit. They also show that an out-of-mode write leaves the contents untouched and that reading resumes at the right address after standby or programming.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;

  // Decoded operating condition of one memory instance
  typedef struct packed {
    logic clr;   // reset/output-enable active: rewind
    logic prog;  // programming mode: writes allowed, read suspended
    logic rd;    // serial read-out active: drive and advance
  } cfg_rom_mode_t;

  function automatic logic rst_pin_active(input logic pin, input logic pol);
    return pol ? pin : ~pin;
  endfunction

endpackage

// File: rtl/cfg_rom_rst_sync.sv
module cfg_rom_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cfg_rom_array.sv
module cfg_rom_array #(
  parameter int DEPTH  = 65536,
  parameter int WORD_W = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int NWORDS = DEPTH / WORD_W
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic              wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic              rbit_o
);

  generate
    if (WORD_W == 1) begin : g_bitwise
      logic mem_q [NWORDS];

      always_ff @(posedge clk) begin
        if (we_i) begin
          mem_q[waddr_i] <= wdata_i;
        end
      end

      assign rbit_o = mem_q[raddr_i];
    end else begin : g_wordwise
      localparam int SEL_W = $clog2(WORD_W);
      localparam int IDX_W = ADDR_W - SEL_W;

      logic [WORD_W-1:0] mem_q [NWORDS];
      logic [IDX_W-1:0]  widx, ridx;
      logic [SEL_W-1:0]  wsel, rsel;
      logic [WORD_W-1:0] wword_d;

      assign {widx, wsel} = waddr_i;
      assign {ridx, rsel} = raddr_i;

      // Merge the new bit into the addressed word
      always_comb begin
        wword_d       = mem_q[widx];
        wword_d[wsel] = wdata_i;
      end

      always_ff @(posedge clk) begin
        if (we_i) begin
          mem_q[widx] <= wword_d;
        end
      end

      assign rbit_o = mem_q[ridx][rsel];
    end
  endgenerate
endmodule

// File: rtl/cfg_rom_addr_ctr.sv
module cfg_rom_addr_ctr #(
  parameter int DEPTH = 65536,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              done_q, done_d;
  logic              upd_en;

  // Next state: rewind has priority, then step or hand over
  always_comb begin
    addr_d = addr_q;
    done_d = done_q;
    upd_en = 1'b0;
    if (clr_i) begin
      addr_d = '0;
      done_d = 1'b0;
      upd_en = 1'b1;
    end else if (adv_i) begin
      upd_en = 1'b1;
      if (addr_q == LAST_ADDR) begin
        done_d = 1'b1;
      end else begin
        addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      done_q <= 1'b0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end

  assign addr_o = addr_q;
  assign done_o = done_q;

  AST_LAST_HANDOVER: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && addr_q == LAST_ADDR) |=> done_q);  // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !clr_i) |=> (done_q && $stable(addr_q)));  // R4
  AST_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (addr_q == '0 && !done_q));  // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> ($stable(addr_q) && $stable(done_q)));  // R7
endmodule

// File: rtl/cfg_rom_mode_dec.sv
module cfg_rom_mode_dec
  import cfg_rom_pkg::*;
(
  input  logic          rst_ok_i,
  input  logic          ce_n_i,
  input  logic          rst_oe_i,
  input  logic          rst_pol_i,
  input  logic          ser_en_n_i,
  input  logic          done_i,
  output cfg_rom_mode_t mode_o
);
  logic clr_act;

  always_comb begin
    clr_act     = rst_pin_active(rst_oe_i, rst_pol_i);
    mode_o.clr  = clr_act;
    mode_o.prog = ~ser_en_n_i;
    mode_o.rd   = rst_ok_i & ~ce_n_i & ser_en_n_i & ~clr_act & ~done_i;
  end
endmodule

// File: rtl/cfg_serial_rom.sv
module cfg_serial_rom
  import cfg_rom_pkg::*;
#(
  parameter int DEPTH  = 65536,
  parameter int WORD_W = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n_i,
  output logic              ceo_n_o,
  input  logic              rst_oe_i,
  input  logic              rst_pol_i,
  input  logic              ser_en_n_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_data_i,
  output logic              data_o,
  output logic              data_en_o
);
  logic              rst_sync_n;
  logic [ADDR_W-1:0] rd_addr;
  logic              done;
  logic              rd_bit;
  logic              wr_go;
  cfg_rom_mode_t     mode;

  cfg_rom_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cfg_rom_mode_dec u_mode (
    .rst_ok_i   (rst_sync_n),
    .ce_n_i     (ce_n_i),
    .rst_oe_i   (rst_oe_i),
    .rst_pol_i  (rst_pol_i),
    .ser_en_n_i (ser_en_n_i),
    .done_i     (done),
    .mode_o     (mode)
  );

  cfg_rom_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (mode.clr),
    .adv_i  (mode.rd),
    .addr_o (rd_addr),
    .done_o (done)
  );

  assign wr_go = wr_en_i & mode.prog;

  cfg_rom_array #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_array (
    .clk     (clk),
    .we_i    (wr_go),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (rd_addr),
    .rbit_o  (rd_bit)
  );

  assign data_en_o = mode.rd;
  assign data_o    = mode.rd & rd_bit;
  assign ceo_n_o   = ~done;

  AST_DRIVE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    data_en_o |-> (!ce_n_i && ceo_n_o));  // R1
  AST_HANDOVER_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ceo_n_o |-> !data_en_o);  // R3
  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ce_n_i |-> !data_en_o);  // R7
  AST_PROG_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ser_en_n_i |-> !data_en_o);  // R8
  AST_RELEASED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !data_en_o |-> !data_o);  // R1
endmodule

// File: tb/sim_cfg_serial_rom.sv
module sim_cfg_serial_rom;
  localparam int D      = 16;
  localparam int WW     = 4;
  localparam int AW     = $clog2(D);

  logic clk, rst_n;
  logic ce0_n, ceo0_n, ceo1_n;
  logic rst_oe, rst_pol, ser_en_n;
  logic wr0, wr1, wdat;
  logic [AW-1:0] waddr;
  logic d0, en0, d1, en1;

  int checks, errors;
  bit finished;

  cfg_serial_rom #(.DEPTH(D), .WORD_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ce0_n), .ceo_n_o(ceo0_n),
    .rst_oe_i(rst_oe), .rst_pol_i(rst_pol), .ser_en_n_i(ser_en_n),
    .wr_en_i(wr0), .wr_addr_i(waddr), .wr_data_i(wdat),
    .data_o(d0), .data_en_o(en0));

  cfg_serial_rom #(.DEPTH(D), .WORD_W(WW)) u1 (
    .clk(clk), .rst_n(rst_n), .ce_n_i(ceo0_n), .ceo_n_o(ceo1_n),
    .rst_oe_i(rst_oe), .rst_pol_i(rst_pol), .ser_en_n_i(ser_en_n),
    .wr_en_i(wr1), .wr_addr_i(waddr), .wr_data_i(wdat),
    .data_o(d1), .data_en_o(en1));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Chain stream bit k (0..2D-1), computed arithmetically
  function automatic logic pat(input int k);
    return 1'(((k * 11 + (k >> 2) * 3 + 1) >> 1) & 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // Bus: drivers count and resolved value
  function automatic int drivers();
    return int'(en0) + int'(en1);
  endfunction

  function automatic int busval();
    return en0 ? int'(d0) : (en1 ? int'(d1) : 2);
  endfunction

  task automatic check_bit(input string req, input int k);
    check({req, " single driver"}, drivers(), 1);
    check({req, " bit"}, busval(), int'(pat(k)));
  endtask

  task automatic stream_all(input string req);
    for (int k = 0; k < 2 * D; k++) begin
      check_bit(req, k);
      if (k < D) check({req, " upstream still active"}, int'(ceo0_n), 1);
      tick();
    end
    check({req, " R3 upstream cascade low"}, int'(ceo0_n), 0);
    check({req, " R3 downstream cascade low"}, int'(ceo1_n), 0);
    check({req, " R3 released at end"}, drivers(), 0);
  endtask

  initial begin
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; ce0_n = 1'b0; rst_oe = 1'b0; rst_pol = 1'b1;
    ser_en_n = 1'b1; wr0 = 1'b0; wr1 = 1'b0; wdat = 1'b0; waddr = '0;
    #2;
    tick(); tick();
    // R10: held in reset
    check("R10 ceo0 high in reset", int'(ceo0_n), 1);
    check("R10 ceo1 high in reset", int'(ceo1_n), 1);
    check("R10 released in reset", drivers(), 0);
    rst_n = 1'b1;
    #1;
    check("R10 still released before sync", drivers(), 0);
    tick();
    check("R10 released after one edge", drivers(), 0);
    tick();
    check("R10 active after two edges", drivers(), 1);

    // R8: programming mode preload
    ser_en_n = 1'b0;
    #1;
    check("R8 released in programming mode", drivers(), 0);
    for (int a = 0; a < D; a++) begin
      waddr = AW'(a);
      wdat = pat(a); wr0 = 1'b1; wr1 = 1'b0; tick();
      wdat = pat(D + a); wr0 = 1'b0; wr1 = 1'b1; tick();
    end
    wr0 = 1'b0; wr1 = 1'b0;
    check("R8 released after preload", drivers(), 0);

    // R9: write outside programming mode ignored
    ser_en_n = 1'b1; ce0_n = 1'b1;
    #1;
    check("R7 released in standby", drivers(), 0);
    waddr = '0; wdat = ~pat(0); wr0 = 1'b1;
    tick();
    wr0 = 1'b0;
    tick(); tick();
    ce0_n = 1'b0;
    #1;
    check("R9 stray write ignored", busval(), int'(pat(0)));

    // R2/R3: full chained stream
    stream_all("R2");
    tick(); tick(); tick();
    check("R4 no wrap upstream", int'(ceo0_n), 0);
    check("R4 no wrap downstream", int'(ceo1_n), 0);
    check("R4 stays released", drivers(), 0);

    // R5: rewind
    rst_oe = 1'b1;
    tick();
    check("R5 ceo0 back high", int'(ceo0_n), 1);
    check("R5 ceo1 back high", int'(ceo1_n), 1);
    check("R1 released while reset/OE active", drivers(), 0);
    rst_oe = 1'b0;
    #1;
    check_bit("R5 restart at 0", 0);
    tick(); tick();
    check_bit("R2 third bit", 2);

    // R7: standby holds the address
    ce0_n = 1'b1;
    #1;
    check("R7 standby released", drivers(), 0);
    tick(); tick(); tick();
    ce0_n = 1'b0;
    #1;
    check_bit("R7 resume same address", 2);

    // R8: programming mode holds the address
    ser_en_n = 1'b0;
    #1;
    check("R8 prog released", drivers(), 0);
    tick(); tick(); tick();
    ser_en_n = 1'b1;
    #1;
    check_bit("R8 resume same address", 2);
    tick();
    check_bit("R2 next bit", 3);

    // R5: mid-stream rewind
    rst_oe = 1'b1;
    #1;
    check("R1 reset/OE releases at once", drivers(), 0);
    tick();
    rst_oe = 1'b0;
    #1;
    check_bit("R5 mid-stream rewind", 0);

    // R6: active-low polarity
    rst_pol = 1'b0; rst_oe = 1'b1;
    #1;
    check_bit("R6 high level inactive", 0);
    tick();
    check_bit("R6 stream continues", 1);
    rst_oe = 1'b0;
    #1;
    check("R6 low level active releases", drivers(), 0);
    tick();
    rst_oe = 1'b1;
    #1;
    check_bit("R6 low level rewinds", 0);
    stream_all("R3 chain active-low");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule